// File: doc/BRIEF.md
# Multi-Channel Mailbox Send Port

This block is the transmit half of an inter-processor mailbox. Local software reaches it through a plain register bus with a write strobe and a combinational read path. To post a 64-bit message to one of eight remote targets, software loads a target number and two 32-bit message words, then writes the trigger register. The block places the message in an ordered send queue. The remote side drains that queue through a pop port that shows the channel number and message at the head.

For each channel the block keeps three status bits. The busy bit is live: it is set while any queued entry still targets that channel. The delivered bit is sticky and is set when the remote pops an entry for that channel. The overflow bit is sticky and is set when a trigger for that channel is refused because the queue is full. Software clears the sticky bits by writing back a copy of the status word to a clear register. One interrupt line combines three sources: a message was delivered, a message was dropped on overflow, and the queue has just become full. Each source has a mask bit, and the pending flag is cleared by writing 1 to it.

Top module: `mbox_tx_port`

## Requirements
- R1: After reset the status word (0x14), the interrupt status (0x18) and `irq` read 0, the mask register (0x1C) reads 3'b111, and `rmt_valid` is 0.
- R2: Writing a value with bit 0 set to the trigger register (0xC) queues {target 0x0 [2:0], high word 0x8, low word 0x4}. The remote port presents queued entries in the order they were triggered: `rmt_chan` carries the target and `rmt_msg` carries {high, low}.
- R3: Status bits [7:0] are busy flags. Bit c is 1 exactly while at least one queued entry targets channel c, so a channel with two queued entries stays busy until the second one is popped.
- R4: A pop while `rmt_valid` is 1 sets delivered flag c in status bits [23:16], where c is the channel of the popped entry.
- R5: A trigger while the queue holds DEPTH entries is dropped. The queue contents and the head entry stay unchanged, and overflow flag c in status bits [15:8] is set for the selected target c.
- R6: A write to the clear register (0x10) clears every delivered flag and overflow flag whose position holds a 1 in the written value (bits [23:16] and [15:8]) and leaves the other flags as they were. A flag set in the same cycle takes priority over the clear.
- R7: The interrupt pending flag (0x18 bit 0) is set by a pop when mask bit 2 is 0, by an overflow drop when mask bit 1 is 0, and by a push that fills the queue when mask bit 0 is 0. A source whose mask bit is 1 never sets it.
- R8: Writing 1 to 0x18 bit 0 clears the pending flag and writing 0 leaves it unchanged. `irq` follows the pending flag.
- R9: A trigger write with bit 0 equal to 0 queues nothing.
- R10: A pop while the queue is empty changes no status bit.
- R11: The target register (3 bits), the two message words and the mask register (3 bits) read back what was last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, decoded combinationally from `bus_addr` |
| irq | output | 1 | Interrupt, high while the pending flag is set |
| rmt_valid | output | 1 | Send queue not empty |
| rmt_chan | output | 3 | Target channel of the head entry |
| rmt_msg | output | 64 | Message of the head entry, {high, low} |
| rmt_pop | input | 1 | Remote takes the head entry |

## Verification
The queue is driven with all eight channels in a permuted order, and each message word is computed from its position. A wrong pointer, a wrong channel field or a swapped word therefore shows up as a distinct miscompare at the remote port. Two entries for the same channel are queued to separate a busy flag that tracks the queue contents from one that a single pop clears. Overflow is triggered on every channel while the queue is full, so the bit position of each flag and the preservation of the head entry are both exposed. Each interrupt source is exercised with its mask bit set and then cleared, which separates the three enables. The clear register is written with alternating patterns to show that it clears bit by bit.

// File: rtl/mbox_tx_port.sv
module mbox_tx_port #(
  parameter int DEPTH = 8,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          rmt_valid,
  output logic [2:0]    rmt_chan,
  output logic [63:0]   rmt_msg,
  input  logic          rmt_pop
);
  localparam int NCH = 8;
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_ID   = AW'(6'h00);
  localparam logic [AW-1:0] A_LO   = AW'(6'h04);
  localparam logic [AW-1:0] A_HI   = AW'(6'h08);
  localparam logic [AW-1:0] A_TRIG = AW'(6'h0C);
  localparam logic [AW-1:0] A_CLR  = AW'(6'h10);
  localparam logic [AW-1:0] A_STS  = AW'(6'h14);
  localparam logic [AW-1:0] A_IRQ  = AW'(6'h18);
  localparam logic [AW-1:0] A_MSK  = AW'(6'h1C);

  logic [2:0]     sel_id;
  logic [31:0]    msg_lo, msg_hi;
  logic [2:0]     q_id  [DEPTH];
  logic [63:0]    q_msg [DEPTH];
  logic [PW-1:0]  rd_ptr, wr_ptr;
  logic [CW-1:0]  cnt;
  logic [NCH-1:0] dlv, ovf, busy;
  logic [DEPTH-1:0] occ;
  logic [2:0]     msk;
  logic           pend;

  logic push_req, full, push, drop, pop, fills, pend_set, pend_clr;
  logic [NCH-1:0] dlv_clr, ovf_clr;

  assign full     = (cnt == CW'(DEPTH));
  assign push_req = bus_wr && bus_addr == A_TRIG && bus_wdata[0];
  assign push     = push_req && !full;
  assign drop     = push_req && full;
  assign pop      = rmt_pop && cnt != '0;
  assign fills    = push && !pop && cnt == CW'(DEPTH - 1);
  assign pend_set = (pop && !msk[2]) || (drop && !msk[1]) || (fills && !msk[0]);
  assign pend_clr = bus_wr && bus_addr == A_IRQ && bus_wdata[0];
  assign dlv_clr  = (bus_wr && bus_addr == A_CLR) ? bus_wdata[23:16] : '0;
  assign ovf_clr  = (bus_wr && bus_addr == A_CLR) ? bus_wdata[15:8] : '0;

  assign rmt_valid = cnt != '0;
  assign rmt_chan  = q_id[rd_ptr];
  assign rmt_msg   = q_msg[rd_ptr];
  assign irq       = pend;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int off;
      off = i - int'(rd_ptr);
      if (off < 0) off = off + DEPTH;
      occ[i] = off < int'(cnt);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_busy
    logic [DEPTH-1:0] hit;
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign hit[i] = occ[i] && q_id[i] == 3'(c);
    end
    assign busy[c] = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_id <= '0;
      msg_lo <= '0;
      msg_hi <= '0;
      msk    <= 3'b111;
    end else if (bus_wr) begin
      if (bus_addr == A_ID)  sel_id <= bus_wdata[2:0];
      if (bus_addr == A_LO)  msg_lo <= bus_wdata;
      if (bus_addr == A_HI)  msg_hi <= bus_wdata;
      if (bus_addr == A_MSK) msk    <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_id[i]  <= '0;
        q_msg[i] <= '0;
      end
    end else begin
      if (push) begin
        q_id[wr_ptr]  <= sel_id;
        q_msg[wr_ptr] <= {msg_hi, msg_lo};
        wr_ptr        <= nxt(wr_ptr);
      end
      if (pop) rd_ptr <= nxt(rd_ptr);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv  <= '0;
      ovf  <= '0;
      pend <= 1'b0;
    end else begin
      dlv  <= (dlv & ~dlv_clr) | (pop ? NCH'(1) << rmt_chan : '0);
      ovf  <= (ovf & ~ovf_clr) | (drop ? NCH'(1) << sel_id : '0);
      pend <= pend_set || (pend && !pend_clr);
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_ID:    bus_rdata = {29'b0, sel_id};
      A_LO:    bus_rdata = msg_lo;
      A_HI:    bus_rdata = msg_hi;
      A_STS:   bus_rdata = {8'b0, dlv, ovf, busy};
      A_IRQ:   bus_rdata = {31'b0, pend};
      A_MSK:   bus_rdata = {29'b0, msk};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbox_tx_port_chk.sv
module mbox_tx_port_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 6,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          rmt_valid,
  input logic [2:0]    rmt_chan,
  input logic          rmt_pop,
  input logic [7:0]    busy,
  input logic [7:0]    dlv,
  input logic [CW-1:0] cnt,
  input logic [2:0]    msk,
  input logic          pend,
  input logic          drop
);
  logic irq_w1c;
  assign irq_w1c = bus_wr && bus_addr == AW'(6'h18) && bus_wdata[0];

  // R3
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rmt_valid |-> busy == 8'h00);

  // R4
  deliver_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rmt_pop && rmt_valid) |=> dlv[$past(rmt_chan)]);

  // R5
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !rmt_pop) |=> cnt == $past(cnt));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == 3'b111 && !pend) |=> !pend);

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_w1c && msk == 3'b111) |=> !pend);
endmodule

bind mbox_tx_port mbox_tx_port_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rmt_valid(rmt_valid), .rmt_chan(rmt_chan),
  .rmt_pop(rmt_pop), .busy(busy), .dlv(dlv), .cnt(cnt), .msk(msk),
  .pend(pend), .drop(drop)
);

// File: tb/test_mbox_tx_port.sv
module test_mbox_tx_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq, rmt_valid, rmt_pop = 0;
  logic [2:0]  rmt_chan;
  logic [63:0] rmt_msg;

  int vectors = 0, fails = 0;
  logic [2:0]  mq_id  [16];
  logic [63:0] mq_msg [16];
  int mh = 0, mt = 0;
  logic [7:0] e_dlv = 0, e_ovf = 0;

  always #2 clk = ~clk;

  mbox_tx_port i_mbox_tx_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rmt_valid(rmt_valid), .rmt_chan(rmt_chan), .rmt_msg(rmt_msg),
    .rmt_pop(rmt_pop)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] busy_exp();
    logic [7:0] b = 0;
    for (int i = mh; i < mt; i++) b[mq_id[i % 16]] = 1'b1;
    return b;
  endfunction

  function automatic logic [31:0] lo_of(input int k);
    return 32'hA500_0000 ^ (k * 32'h0001_0203);
  endfunction

  function automatic logic [31:0] hi_of(input int k);
    return ~lo_of(k) + k;
  endfunction

  task automatic send(input logic [2:0] ch, input int k);
    wr(6'h00, {29'b0, ch});
    wr(6'h04, lo_of(k));
    wr(6'h08, hi_of(k));
    wr(6'h0C, 32'h1);
    if (mt - mh < 8) begin
      mq_id[mt % 16] = ch;
      mq_msg[mt % 16] = {hi_of(k), lo_of(k)};
      mt++;
    end else e_ovf[ch] = 1'b1;
  endtask

  task automatic status(input string req);
    logic [31:0] v;
    rd(6'h14, v);
    check(req, v, {8'h00, e_dlv, e_ovf, busy_exp()});
  endtask

  task automatic take(input string req);
    check({req, " valid"}, rmt_valid, 1);
    check({req, " chan"}, rmt_chan, mq_id[mh % 16]);
    check({req, " msg"}, rmt_msg, mq_msg[mh % 16]);
    e_dlv[mq_id[mh % 16]] = 1'b1;
    mh++;
    @(negedge clk); rmt_pop = 1;
    @(negedge clk); rmt_pop = 0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    status("R1 status");
    rd(6'h1C, v); check("R1 mask", v, 32'h7);
    rd(6'h18, v); check("R1 irq status", v, 0);
    check("R1 irq", irq, 0);
    check("R1 valid", rmt_valid, 0);

    // R11 readback
    wr(6'h00, 32'hFFFF_FFFD); rd(6'h00, v); check("R11 id", v, 32'h5);
    wr(6'h04, 32'h1234_5678); rd(6'h04, v); check("R11 lo", v, 32'h1234_5678);
    wr(6'h08, 32'h9ABC_DEF0); rd(6'h08, v); check("R11 hi", v, 32'h9ABC_DEF0);
    wr(6'h1C, 32'h2); rd(6'h1C, v); check("R11 mask", v, 32'h2);
    wr(6'h1C, 32'h7);

    // R9 trigger with bit 0 clear
    wr(6'h0C, 32'hFFFF_FFFE);
    check("R9 valid", rmt_valid, 0);
    status("R9 status");

    // R10 pop on empty queue
    @(negedge clk); rmt_pop = 1; @(negedge clk); rmt_pop = 0;
    status("R10 status");
    check("R10 valid", rmt_valid, 0);

    // R2 R3 fill with permuted channels
    for (int k = 0; k < 8; k++) begin
      send(3'((k * 3 + 1) % 8), k);
      status("R3 busy after push");
    end
    check("R7 masked block irq", irq, 0);

    // R5 overflow on every channel
    for (int c = 0; c < 8; c++) begin
      send(3'(c), 20 + c);
      status("R5 overflow flags");
      check("R5 head chan", rmt_chan, mq_id[mh % 16]);
      check("R5 head msg", rmt_msg, mq_msg[mh % 16]);
    end
    check("R7 masked overflow irq", irq, 0);

    // R7 R8 overflow interrupt unmasked
    wr(6'h1C, 32'h5);
    send(3'd2, 40);
    check("R7 overflow irq", irq, 1);
    wr(6'h18, 32'h0);
    check("R8 write 0 keeps", irq, 1);
    wr(6'h18, 32'h1);
    check("R8 w1c", irq, 0);
    rd(6'h18, v); check("R8 status", v, 0);

    // R6 bitwise clear of overflow flags
    wr(6'h10, 32'h0000_5500);
    e_ovf = e_ovf & ~8'h55;
    status("R6 partial clear");

    // R2 R4 R7 drain with deliver interrupt enabled
    wr(6'h1C, 32'h3);
    for (int k = 0; k < 8; k++) begin
      take("R2 pop order");
      status("R4 deliver flags");
      check("R7 deliver irq", irq, 1);
      wr(6'h18, 32'h1);
    end
    check("R3 empty", rmt_valid, 0);

    // R6 clear delivered and remaining overflow
    wr(6'h10, 32'h00AA_AA00);
    e_dlv = e_dlv & ~8'hAA; e_ovf = e_ovf & ~8'hAA;
    status("R6 mixed clear");
    wr(6'h10, 32'h00FF_FF00);
    e_dlv = 0; e_ovf = 0;
    status("R6 full clear");

    // R3 two entries for one channel
    wr(6'h1C, 32'h7);
    send(3'd3, 50);
    send(3'd3, 51);
    take("R2 dup first");
    status("R3 still busy");
    take("R2 dup second");
    status("R3 idle");

    // R7 block interrupt on fill
    wr(6'h1C, 32'h6);
    for (int k = 0; k < 7; k++) send(3'(k), 60 + k);
    check("R7 not yet full", irq, 0);
    send(3'd7, 67);
    check("R7 full irq", irq, 1);
    wr(6'h1C, 32'h7);
    wr(6'h18, 32'h1);
    for (int k = 0; k < 8; k++) take("R2 final drain");
    status("R4 final");
    check("R8 quiet", irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule